// File: doc/BRIEF.md
# Programmable Frame Decimator

This block lowers the rate of a multichannel sample stream by forwarding one whole frame out of every N and discarding the others. A frame is a group of consecutive samples with one sample for each active channel. The block never averages or mixes frames. It only decides, frame by frame, whether that frame is forwarded unchanged.

An 8-bit control register sets N, and N is the stored value plus one. Software can write and read this register at any time, but a written value stays pending and has no effect on the stream. A synchronous converter-reset strobe copies the pending value into the working configuration and restarts the frame sequence, so the first frame after the strobe is always forwarded. The number of active channels is a static input. The upstream source can also mark the first sample of each frame, and that mark realigns the block's channel position.

Top module: `frame_decimator`

## Requirements
- R1: After the asynchronous reset, `out_valid` is 0, `cfg_rd_data` reads 0 and the working factor is 1, so every frame is forwarded.
- R2: One cycle after a write, `cfg_rd_data` returns the value written. It keeps that value until the next write.
- R3: With a working value of 0, every accepted sample is forwarded.
- R4: With a working value of 1, the first frame after the strobe is forwarded, the next is dropped, and the pattern alternates from there.
- R5: With a working value V (0 to 255), the frames counted from the last strobe are numbered from 0. Frame k is forwarded exactly when k mod (V+1) is 0. V=255 forwards one frame in 256.
- R6: A register write that is not followed by a strobe leaves the forwarding pattern unchanged, and the frame sequence carries on without a restart.
- R7: `adc_reset` loads the pending value and clears the frame count, so the next frame is forwarded. A sample presented in the same cycle as the strobe is discarded.
- R8: Every sample of a forwarded frame appears on `out_data` exactly one cycle after it is accepted, in its original order. `out_first` is 1 on the frame's channel-0 sample and 0 on every other sample. Every sample of a dropped frame is discarded.
- R9: A sample with `in_first`=1 is treated as channel 0 of a new frame, even if the previous frame was incomplete. An incomplete frame does not advance the frame count.
- R10: A frame ends after `num_ch` accepted samples. A `num_ch` value of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_data | input | 8 | Value to store (factor minus one) |
| cfg_rd_data | output | 8 | Last value written |
| adc_reset | input | 1 | Synchronous strobe: apply pending value, restart frames |
| num_ch | input | CH_W (5) | Active channels per frame, static |
| in_valid | input | 1 | Input sample present |
| in_first | input | 1 | Input sample is channel 0 of a frame |
| in_data | input | DATA_W (16) | Input sample |
| out_valid | output | 1 | Output sample present |
| out_first | output | 1 | Output sample is channel 0 of its frame |
| out_data | output | DATA_W (16) | Output sample |

## Verification
The assertions assume that `num_ch` only changes between frames, while the channel position is 0. They also assume that `cfg_wr_en` and `adc_reset` are held low during reset, so that the first `$past` values are defined. The bench meets these conditions by changing `num_ch` only after a full frame or right after a strobe. It drives every control input to 0 before releasing reset. Strobes with a sample present in the same cycle are applied on purpose, to exercise the rule that such a sample is discarded.

// File: rtl/fd_pkg.sv
package fd_pkg;
  localparam int CFG_W = 8;

  // Next frame count, wrapping to zero once the limit (factor-1) is reached.
  function automatic logic [CFG_W-1:0] fd_next_count(input logic [CFG_W-1:0] cnt,
                                                      input logic [CFG_W-1:0] limit);
    return (cnt >= limit) ? '0 : cnt + 1'b1;
  endfunction

  // A frame is forwarded when its position inside the decimation period is zero.
  function automatic logic fd_keep(input logic [CFG_W-1:0] cnt);
    return (cnt == '0);
  endfunction
endpackage

// File: rtl/fd_cfg_regs.sv
module fd_cfg_regs #(
  parameter int CFG_W = fd_pkg::CFG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             load,
  output logic [CFG_W-1:0] pending_o,
  output logic [CFG_W-1:0] active_o
);
  logic [CFG_W-1:0] pending_q;
  logic [CFG_W-1:0] active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= '0;
    end else if (wr_en) begin
      pending_q <= wr_data;
    end
  end

  // The working copy only follows the pending value on the strobe.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= '0;
    end else if (load) begin
      active_q <= pending_q;
    end
  end

  assign pending_o = pending_q;
  assign active_o  = active_q;
endmodule

// File: rtl/fd_chan_tracker.sv
module fd_chan_tracker #(
  parameter int CH_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            accept,
  input  logic            mark_first,
  input  logic [CH_W-1:0] num_ch,
  output logic            is_head,
  output logic            is_last
);
  logic [CH_W-1:0] idx_q;
  logic [CH_W-1:0] eff_idx;
  logic [CH_W-1:0] last_idx;

  function automatic logic [CH_W-1:0] last_index(input logic [CH_W-1:0] n);
    return (n == '0) ? '0 : n - 1'b1;
  endfunction

  assign eff_idx  = mark_first ? '0 : idx_q;
  assign last_idx = last_index(num_ch);
  assign is_head  = (eff_idx == '0);
  assign is_last  = (eff_idx >= last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (clear) begin
      idx_q <= '0;
    end else if (accept) begin
      idx_q <= is_last ? '0 : eff_idx + 1'b1;
    end
  end
endmodule

// File: rtl/fd_frame_gate.sv
module fd_frame_gate #(
  parameter int CFG_W = fd_pkg::CFG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             accept,
  input  logic             is_head,
  input  logic             is_last,
  input  logic [CFG_W-1:0] limit,
  output logic             pass,
  output logic [CFG_W-1:0] frame_cnt
);
  logic [CFG_W-1:0] cnt_q;
  logic             keep_q;

  // The decision is taken on the head sample and held for the rest of the frame.
  assign pass      = is_head ? fd_pkg::fd_keep(cnt_q) : keep_q;
  assign frame_cnt = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      keep_q <= 1'b1;
    end else if (clear) begin
      cnt_q  <= '0;
      keep_q <= 1'b1;
    end else if (accept) begin
      keep_q <= pass;
      if (is_last) begin
        cnt_q <= fd_pkg::fd_next_count(cnt_q, limit);
      end
    end
  end
endmodule

// File: rtl/frame_decimator.sv
module frame_decimator #(
  parameter int DATA_W = 16,
  parameter int CH_W   = 5,
  parameter int CFG_W  = fd_pkg::CFG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [CFG_W-1:0]  cfg_wr_data,
  output logic [CFG_W-1:0]  cfg_rd_data,
  input  logic              adc_reset,
  input  logic [CH_W-1:0]   num_ch,
  input  logic              in_valid,
  input  logic              in_first,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic              out_first,
  output logic [DATA_W-1:0] out_data
);
  logic [CFG_W-1:0] active_cfg;
  logic [CFG_W-1:0] frame_cnt;
  logic             accept;
  logic             frame_head;
  logic             frame_last;
  logic             frame_pass;

  // A strobe takes precedence over a sample in the same cycle.
  assign accept = in_valid & ~adc_reset;

  fd_cfg_regs #(.CFG_W(CFG_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_wr_en),
    .wr_data   (cfg_wr_data),
    .load      (adc_reset),
    .pending_o (cfg_rd_data),
    .active_o  (active_cfg)
  );

  fd_chan_tracker #(.CH_W(CH_W)) u_chan (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (adc_reset),
    .accept     (accept),
    .mark_first (in_first),
    .num_ch     (num_ch),
    .is_head    (frame_head),
    .is_last    (frame_last)
  );

  fd_frame_gate #(.CFG_W(CFG_W)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (adc_reset),
    .accept    (accept),
    .is_head   (frame_head),
    .is_last   (frame_last),
    .limit     (active_cfg),
    .pass      (frame_pass),
    .frame_cnt (frame_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_first <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= accept & frame_pass;
      out_first <= accept & frame_pass & frame_head;
      if (accept & frame_pass) begin
        out_data <= in_data;
      end
    end
  end
endmodule

// File: rtl/fd_checker.sv
module fd_checker #(
  parameter int CFG_W = fd_pkg::CFG_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr_en,
  input logic [CFG_W-1:0] cfg_wr_data,
  input logic [CFG_W-1:0] cfg_rd_data,
  input logic             adc_reset,
  input logic             in_valid,
  input logic             out_valid,
  input logic             out_first,
  input logic [CFG_W-1:0] active_cfg,
  input logic [CFG_W-1:0] frame_cnt,
  input logic             frame_pass
);
  p_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_wr_en) |-> cfg_rd_data == $past(cfg_wr_data));

  p_passthru_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active_cfg == '0 && in_valid && !adc_reset) |=> out_valid);

  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_cnt <= active_cfg);

  p_drop_on_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(adc_reset) |-> !out_valid);

  p_first_after_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(adc_reset) && in_valid && !adc_reset) |-> frame_pass);

  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  p_first_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_first |-> out_valid);
endmodule

bind frame_decimator fd_checker #(.CFG_W(CFG_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_wr_en   (cfg_wr_en),
  .cfg_wr_data (cfg_wr_data),
  .cfg_rd_data (cfg_rd_data),
  .adc_reset   (adc_reset),
  .in_valid    (in_valid),
  .out_valid   (out_valid),
  .out_first   (out_first),
  .active_cfg  (active_cfg),
  .frame_cnt   (frame_cnt),
  .frame_pass  (frame_pass)
);

// File: tb/frame_decimator_tb.sv
module frame_decimator_tb;
  localparam int DATA_W = 16;
  localparam int CH_W   = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_wr_en = 1'b0;
  logic [7:0]        cfg_wr_data = '0;
  logic [7:0]        cfg_rd_data;
  logic              adc_reset = 1'b0;
  logic [CH_W-1:0]   num_ch = 5'd3;
  logic              in_valid = 1'b0;
  logic              in_first = 1'b0;
  logic [DATA_W-1:0] in_data = '0;
  logic              out_valid;
  logic              out_first;
  logic [DATA_W-1:0] out_data;

  int vectors = 0;
  int fails   = 0;
  int fidx    = 0;
  logic [DATA_W-1:0] seq = 16'h1000;
  bit done = 1'b0;

  logic [DATA_W-1:0] exp_data[$];
  logic              exp_first[$];
  string             exp_req[$];

  always #4 clk = ~clk;

  frame_decimator #(.DATA_W(DATA_W), .CH_W(CH_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .adc_reset(adc_reset), .num_ch(num_ch),
    .in_valid(in_valid), .in_first(in_first), .in_data(in_data),
    .out_valid(out_valid), .out_first(out_first), .out_data(out_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Monitor: compare every produced sample against the scoreboard head.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_data.size() == 0) begin
        check(1'b0, "R8 unexpected output", int'(out_data), 0);
      end else begin
        logic [DATA_W-1:0] d;
        logic f;
        string r;
        d = exp_data.pop_front();
        f = exp_first.pop_front();
        r = exp_req.pop_front();
        check(out_data == d && out_first == f, r,
              int'({out_first, out_data}), int'({f, d}));
      end
    end
  end

  task automatic wr_cfg(input logic [7:0] v);
    cfg_wr_en = 1'b1; cfg_wr_data = v;
    tick();
    cfg_wr_en = 1'b0;
    check(cfg_rd_data == v, "R2 readback", int'(cfg_rd_data), int'(v));
  endtask

  // Strobe; optionally with a sample in the same cycle, which must be dropped (R7).
  task automatic strobe(input bit with_sample);
    adc_reset = 1'b1;
    in_valid = with_sample; in_first = with_sample; in_data = 16'hDEAD;
    tick();
    adc_reset = 1'b0; in_valid = 1'b0; in_first = 1'b0;
    fidx = 0;
  endtask

  task automatic send(input logic first_mark, input bit kept, input bit head, input string req);
    in_valid = 1'b1; in_first = first_mark; in_data = seq;
    if (kept) begin
      exp_data.push_back(seq); exp_first.push_back(head); exp_req.push_back(req);
    end
    seq++;
    tick();
    in_valid = 1'b0; in_first = 1'b0;
  endtask

  task automatic run_frames(input int n, input int nch, input int factor, input bit gap,
                            input bit mark, input string req);
    for (int k = 0; k < n; k++) begin
      bit kept;
      kept = (fidx % factor) == 0;
      for (int c = 0; c < nch; c++) begin
        send(mark && (c == 0), kept, c == 0, req);
        if (gap) tick();
      end
      fidx++;
    end
  endtask

  task automatic partial(input int n, input int factor, input string req);
    bit kept;
    kept = (fidx % factor) == 0;
    for (int c = 0; c < n; c++) send(c == 0, kept, c == 0, req);
  endtask

  task automatic drain(input string req);
    repeat (4) tick();
    check(exp_data.size() == 0, req, exp_data.size(), 0);
  endtask

  initial begin
    repeat (3) tick();
    check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    check(cfg_rd_data == 8'd0, "R1 cfg_rd_data after reset", int'(cfg_rd_data), 0);
    rst_n = 1'b1;
    tick();

    run_frames(4, 3, 1, 1'b0, 1'b1, "R1 R3 default pass-through");
    drain("R3 drain");

    wr_cfg(8'd1);
    run_frames(3, 3, 1, 1'b1, 1'b1, "R6 pending write ignored");
    drain("R6 drain");

    strobe(1'b0);
    run_frames(6, 3, 2, 1'b0, 1'b1, "R4 every second frame");
    drain("R4 drain");

    wr_cfg(8'd4);
    strobe(1'b0);
    run_frames(10, 3, 5, 1'b1, 1'b0, "R5 factor 5");
    wr_cfg(8'd0);
    run_frames(7, 3, 5, 1'b0, 1'b1, "R6 factor kept without strobe");
    drain("R6 drain 2");

    wr_cfg(8'd2);
    strobe(1'b1);
    run_frames(4, 3, 3, 1'b0, 1'b1, "R7 first frame after strobe");
    drain("R7 drain");

    strobe(1'b0);
    partial(2, 3, "R9 partial kept frame");
    run_frames(2, 3, 3, 1'b0, 1'b1, "R9 restart same frame");
    partial(1, 3, "R9 partial dropped frame");
    run_frames(3, 3, 3, 1'b0, 1'b1, "R9 resumed sequence");
    drain("R9 drain");

    num_ch = 5'd0;
    strobe(1'b0);
    run_frames(7, 1, 3, 1'b0, 1'b0, "R10 zero channels as one");
    num_ch = 5'd5;
    run_frames(5, 5, 3, 1'b1, 1'b0, "R10 five channels");
    drain("R10 drain");

    num_ch = 5'd1;
    wr_cfg(8'd255);
    strobe(1'b0);
    run_frames(520, 1, 256, 1'b0, 1'b1, "R5 factor 256");
    drain("R5 drain");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      vectors++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule